// File: doc/BRIEF.md
# Non-blocking read cache miss controller

This block is the control path of a read-only cache that keeps serving requests while misses are outstanding. For each request it reads the lookup status and line index that an external tag array reports for the request's block. It also reads whether an external miss table already tracks that block, and whether the table has room for one more request on it. From these it decides one of four outcomes. The request can hit. It can merge into a miss that is already in flight. It can start a new miss. It can be turned away. It then drives the access and add strobes that the two tables act on in the same cycle.

A new miss is recorded in a small store indexed by the request's tag. The store keeps the block address and the line index. The tag and block address go into a bounded queue, which drains into the lower-level memory port whenever that port is not full. When memory answers with a fill carrying the same tag, the stored record is read out. The tag array is told to fill the line, either by line index or by block address, depending on the allocation mode the block was built for. The miss table is told the block is ready, and the record is released. A flush request is passed on to the tag array as a flash invalidate.

Top module: `nbc_miss_ctrl`

## Requirements
- R1: A request whose lookup status is hit (tag_status 0) gets response status 0, raises neither tag_access_en nor mshr_add_en, and adds no queue entry.
- R2: A request with lookup status 1 or 2, mshr_hit high and mshr_full low is merged. tag_access_en and mshr_add_en are raised in the request cycle. The response status is 1. No queue entry and no tag record are made, so a later fill with that tag is reported as an error.
- R3: A request with lookup status 1 or 2, mshr_hit low, mshr_full low and fewer than Q_DEPTH queued misses is a new miss. It raises tag_access_en and mshr_add_en, gets response status 1, records the block address and line index under req_tag, and joins the queue.
- R4: A request is rejected with response status 2 and no strobes in three cases: lookup status 3, mshr_full high, or a new miss arriving while the queue holds Q_DEPTH entries.
- R5: resp_valid rises in the cycle after each request, with resp_tag equal to that request's tag. With no request, resp_valid is low.
- R6: mem_push is high exactly when the queue is non-empty and mem_full is low. Queued misses leave in arrival order, with the block-aligned address (low log2(LINE_BYTES) bits zero) and their tag. While mem_full is high the head stays in place.
- R7: In the cycle of a fill with a recorded tag, mshr_ready_en is raised with the recorded block address. When ALLOC_ON_FILL is 0, tag_fill_by_idx is raised with the recorded line index. When ALLOC_ON_FILL is 1, tag_fill_by_addr is raised with the recorded block address.
- R8: A fill releases its record, so a second fill with the same tag raises no fill strobes and sets fill_err in the next cycle.
- R9: A fill whose tag was never recorded raises no fill strobes and sets fill_err for one cycle, in the cycle after the fill.
- R10: tag_flush follows flush with one cycle of delay.
- R11: After reset, resp_valid, mem_push, fill_err and tag_flush are low, and the queue and record store are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Flash-invalidate request |
| req_valid | input | 1 | Access request present |
| req_addr | input | ADDR_W | Byte address of the request |
| req_tag | input | TAG_W | Tag that names the request |
| blk_addr | output | ADDR_W | Block-aligned address presented to both tables |
| tag_status | input | 2 | Lookup result: 0 hit, 1 hit on pending line, 2 miss, 3 cannot allocate |
| tag_probe_idx | input | IDX_W | Line index chosen by the tag array |
| tag_access_en | output | 1 | Touch or allocate the probed line |
| mshr_hit | input | 1 | Miss table already tracks the block |
| mshr_full | input | 1 | Miss table has no room for this request |
| mshr_add_en | output | 1 | Add the request to the miss table |
| resp_valid | output | 1 | Response present |
| resp_status | output | 2 | 0 hit, 1 miss accepted, 2 rejected |
| resp_tag | output | TAG_W | Tag of the answered request |
| mem_push | output | 1 | Miss sent to memory this cycle |
| mem_addr | output | ADDR_W | Block address of the sent miss |
| mem_tag | output | TAG_W | Tag of the sent miss |
| mem_full | input | 1 | Memory port cannot accept |
| fill_valid | input | 1 | Fill returned from memory |
| fill_tag | input | TAG_W | Tag of the fill |
| tag_fill_by_idx | output | 1 | Fill the tag array by line index |
| tag_fill_idx | output | IDX_W | Recorded line index |
| tag_fill_by_addr | output | 1 | Fill the tag array by block address |
| tag_fill_addr | output | ADDR_W | Recorded block address |
| mshr_ready_en | output | 1 | Mark the block ready in the miss table |
| mshr_ready_addr | output | ADDR_W | Block to mark ready |
| fill_err | output | 1 | Fill arrived for a tag with no record |
| tag_flush | output | 1 | Flash invalidate to the tag array |

## Verification
The hardest case to reach is a rejection caused only by the queue being full, with the miss table still willing. To get there, the bench holds mem_full high through the whole vector walk. Four new misses then pile up, and the fifth is offered with a clean table. After that the port is released part way and clamped again, to show the head staying put before the rest drains in order. A fill for a merged request confirms that merging left no record behind.

// File: rtl/nbc_pkg.sv
package nbc_pkg;
  typedef enum logic [1:0] {
    LK_HIT      = 2'd0,
    LK_HIT_PEND = 2'd1,
    LK_MISS     = 2'd2,
    LK_FAIL     = 2'd3
  } lookup_e;

  typedef enum logic [1:0] {
    RS_HIT    = 2'd0,
    RS_MISS   = 2'd1,
    RS_REJECT = 2'd2
  } resp_e;
endpackage

// File: rtl/nbc_decide.sv
module nbc_decide
  import nbc_pkg::*;
(
  input  logic       req_valid,
  input  logic [1:0] lookup,
  input  logic       pend_hit,
  input  logic       pend_full,
  input  logic       q_room,
  output logic       do_merge,
  output logic       do_fresh,
  output logic [1:0] status
);
  lookup_e lk;

  always_comb begin
    lk       = lookup_e'(lookup);
    do_merge = 1'b0;
    do_fresh = 1'b0;
    status   = RS_REJECT;
    if (lk == LK_HIT) begin
      status = RS_HIT;
    end else if (lk != LK_FAIL && !pend_full) begin
      if (pend_hit) begin
        do_merge = req_valid;
        status   = RS_MISS;
      end else if (q_room) begin
        do_fresh = req_valid;
        status   = RS_MISS;
      end
    end
  end
endmodule

// File: rtl/nbc_missq.sv
module nbc_missq #(
  parameter int DEPTH = 4,
  parameter int W     = 30
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         nonempty,
  output logic         room
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [W-1:0]     store [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             do_pop;

  assign nonempty = (count != '0);
  assign room     = (count != FULL_CNT);
  assign do_pop   = pop && nonempty;
  assign head     = store[rd_ptr];

  always_ff @(posedge clk) begin
    if (push && room) store[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push && room) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
      if (do_pop)       rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
      case ({push && room, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/nbc_meta.sv
module nbc_meta #(
  parameter int  TAG_W         = 4,
  parameter int  BLK_W         = 26,
  parameter int  IDX_W         = 8,
  parameter bit  ALLOC_ON_FILL = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [BLK_W-1:0] wr_blk,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             fill_valid,
  input  logic [TAG_W-1:0] fill_tag,
  output logic             by_idx,
  output logic             by_addr,
  output logic [IDX_W-1:0] rd_idx,
  output logic [BLK_W-1:0] rd_blk,
  output logic             ready_en,
  output logic             no_record
);
  localparam int NTAGS = 1 << TAG_W;

  logic [NTAGS-1:0] live;
  logic [BLK_W-1:0] blk_mem [NTAGS];
  logic [IDX_W-1:0] idx_mem [NTAGS];
  logic             hit;

  assign hit       = fill_valid && live[fill_tag];
  assign ready_en  = hit;
  assign no_record = fill_valid && !live[fill_tag];
  assign rd_idx    = idx_mem[fill_tag];
  assign rd_blk    = blk_mem[fill_tag];

  generate
    if (ALLOC_ON_FILL) begin : g_by_addr
      assign by_addr = hit;
      assign by_idx  = 1'b0;
    end else begin : g_by_idx
      assign by_idx  = hit;
      assign by_addr = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (wr_en) begin
      blk_mem[wr_tag] <= wr_blk;
      idx_mem[wr_tag] <= wr_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live <= '0;
    end else begin
      if (hit)   live[fill_tag] <= 1'b0;
      if (wr_en) live[wr_tag]   <= 1'b1;
    end
  end
endmodule

// File: rtl/nbc_miss_ctrl.sv
module nbc_miss_ctrl
  import nbc_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int LINE_BYTES    = 64,
  parameter int IDX_W         = 8,
  parameter int TAG_W         = 4,
  parameter int Q_DEPTH       = 4,
  parameter bit ALLOC_ON_FILL = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [TAG_W-1:0]  req_tag,
  output logic [ADDR_W-1:0] blk_addr,
  input  logic [1:0]        tag_status,
  input  logic [IDX_W-1:0]  tag_probe_idx,
  output logic              tag_access_en,
  input  logic              mshr_hit,
  input  logic              mshr_full,
  output logic              mshr_add_en,
  output logic              resp_valid,
  output logic [1:0]        resp_status,
  output logic [TAG_W-1:0]  resp_tag,
  output logic              mem_push,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [TAG_W-1:0]  mem_tag,
  input  logic              mem_full,
  input  logic              fill_valid,
  input  logic [TAG_W-1:0]  fill_tag,
  output logic              tag_fill_by_idx,
  output logic [IDX_W-1:0]  tag_fill_idx,
  output logic              tag_fill_by_addr,
  output logic [ADDR_W-1:0] tag_fill_addr,
  output logic              mshr_ready_en,
  output logic [ADDR_W-1:0] mshr_ready_addr,
  output logic              fill_err,
  output logic              tag_flush
);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int BLK_W = ADDR_W - OFF_W;
  localparam int Q_W   = BLK_W + TAG_W;

  logic [BLK_W-1:0] req_blk;
  logic             do_merge, do_fresh, q_room, q_nonempty;
  logic [1:0]       status;
  logic [Q_W-1:0]   q_head;
  logic [BLK_W-1:0] rec_blk;
  logic             no_record;

  assign req_blk  = req_addr[ADDR_W-1:OFF_W];
  assign blk_addr = {req_blk, {OFF_W{1'b0}}};

  nbc_decide u_decide (
    .req_valid (req_valid),
    .lookup    (tag_status),
    .pend_hit  (mshr_hit),
    .pend_full (mshr_full),
    .q_room    (q_room),
    .do_merge  (do_merge),
    .do_fresh  (do_fresh),
    .status    (status)
  );

  assign tag_access_en = do_merge || do_fresh;
  assign mshr_add_en   = do_merge || do_fresh;

  nbc_missq #(.DEPTH(Q_DEPTH), .W(Q_W)) u_q (
    .clk      (clk),
    .rst      (rst),
    .push     (do_fresh),
    .din      ({req_blk, req_tag}),
    .pop      (!mem_full),
    .head     (q_head),
    .nonempty (q_nonempty),
    .room     (q_room)
  );

  assign mem_push = q_nonempty && !mem_full;
  assign mem_addr = {q_head[Q_W-1:TAG_W], {OFF_W{1'b0}}};
  assign mem_tag  = q_head[TAG_W-1:0];

  nbc_meta #(
    .TAG_W(TAG_W), .BLK_W(BLK_W), .IDX_W(IDX_W), .ALLOC_ON_FILL(ALLOC_ON_FILL)
  ) u_meta (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (do_fresh),
    .wr_tag     (req_tag),
    .wr_blk     (req_blk),
    .wr_idx     (tag_probe_idx),
    .fill_valid (fill_valid),
    .fill_tag   (fill_tag),
    .by_idx     (tag_fill_by_idx),
    .by_addr    (tag_fill_by_addr),
    .rd_idx     (tag_fill_idx),
    .rd_blk     (rec_blk),
    .ready_en   (mshr_ready_en),
    .no_record  (no_record)
  );

  assign tag_fill_addr   = {rec_blk, {OFF_W{1'b0}}};
  assign mshr_ready_addr = {rec_blk, {OFF_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid  <= 1'b0;
      resp_status <= RS_HIT;
      resp_tag    <= '0;
      fill_err    <= 1'b0;
      tag_flush   <= 1'b0;
    end else begin
      resp_valid  <= req_valid;
      resp_status <= status;
      resp_tag    <= req_tag;
      fill_err    <= no_record;
      tag_flush   <= flush;
    end
  end
endmodule

// File: rtl/nbc_miss_ctrl_chk.sv
module nbc_miss_ctrl_chk #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              flush,
  input logic              req_valid,
  input logic [1:0]        tag_status,
  input logic              mshr_full,
  input logic              tag_access_en,
  input logic              mshr_add_en,
  input logic              resp_valid,
  input logic              mem_push,
  input logic              mem_full,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              fill_valid,
  input logic              tag_fill_by_idx,
  input logic              tag_fill_by_addr,
  input logic              mshr_ready_en,
  input logic              fill_err,
  input logic              tag_flush
);
  localparam int OFF_W = $clog2(LINE_BYTES);

  // R1
  hit_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && tag_status == 2'd0) |-> (!tag_access_en && !mshr_add_en));

  // R4
  reject_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (tag_status == 2'd3 || mshr_full)) |-> (!tag_access_en && !mshr_add_en));

  // R5
  resp_follow_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> resp_valid);

  // R6
  port_full_chk: assert property (@(posedge clk) disable iff (rst)
    mem_full |-> !mem_push);

  // R6
  aligned_chk: assert property (@(posedge clk) disable iff (rst)
    mem_push |-> (mem_addr[OFF_W-1:0] == '0));

  // R7
  fill_route_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({tag_fill_by_idx, tag_fill_by_addr}) &&
    ((tag_fill_by_idx || tag_fill_by_addr) == mshr_ready_en));

  // R9
  err_cause_chk: assert property (@(posedge clk) disable iff (rst)
    fill_err |-> ($past(fill_valid) && !$past(mshr_ready_en)));

  // R10
  flush_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> tag_flush);
endmodule

bind nbc_miss_ctrl nbc_miss_ctrl_chk #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_chk (
  .clk              (clk),
  .rst              (rst),
  .flush            (flush),
  .req_valid        (req_valid),
  .tag_status       (tag_status),
  .mshr_full        (mshr_full),
  .tag_access_en    (tag_access_en),
  .mshr_add_en      (mshr_add_en),
  .resp_valid       (resp_valid),
  .mem_push         (mem_push),
  .mem_full         (mem_full),
  .mem_addr         (mem_addr),
  .fill_valid       (fill_valid),
  .tag_fill_by_idx  (tag_fill_by_idx),
  .tag_fill_by_addr (tag_fill_by_addr),
  .mshr_ready_en    (mshr_ready_en),
  .fill_err         (fill_err),
  .tag_flush        (tag_flush)
);

// File: tb/sim_nbc_miss_ctrl.sv
`timescale 1ns/1ps
module sim_nbc_miss_ctrl;
  localparam int ADDR_W = 32;
  localparam int IDX_W  = 8;
  localparam int TAG_W  = 4;
  localparam int NVEC   = 13;

  // {lookup[1:0], mshr_hit, mshr_full, exp_status[1:0], exp_strobe}
  localparam logic [6:0] VEC [NVEC] = '{
    {2'd0, 1'b0, 1'b0, 2'd0, 1'b0},  // 0 R1 hit
    {2'd0, 1'b1, 1'b1, 2'd0, 1'b0},  // 1 R1 hit ignores table
    {2'd3, 1'b0, 1'b0, 2'd2, 1'b0},  // 2 R4 lookup fail
    {2'd2, 1'b1, 1'b0, 2'd1, 1'b1},  // 3 R2 merge
    {2'd2, 1'b1, 1'b1, 2'd2, 1'b0},  // 4 R4 no merge room
    {2'd2, 1'b0, 1'b1, 2'd2, 1'b0},  // 5 R4 no entry
    {2'd2, 1'b0, 1'b0, 2'd1, 1'b1},  // 6 R3 new
    {2'd1, 1'b1, 1'b0, 2'd1, 1'b1},  // 7 R2 merge on pending line
    {2'd1, 1'b0, 1'b0, 2'd1, 1'b1},  // 8 R3 new
    {2'd2, 1'b0, 1'b0, 2'd1, 1'b1},  // 9 R3 new
    {2'd2, 1'b0, 1'b0, 2'd1, 1'b1},  // 10 R3 new, queue now full
    {2'd2, 1'b0, 1'b0, 2'd2, 1'b0},  // 11 R4 queue full
    {2'd2, 1'b1, 1'b0, 2'd1, 1'b1}   // 12 R2 merge while queue full
  };

  logic clk = 1'b0;
  logic rst, flush, req_valid, mshr_hit, mshr_full, mem_full, fill_valid;
  logic [ADDR_W-1:0] req_addr;
  logic [TAG_W-1:0]  req_tag, fill_tag;
  logic [1:0]        tag_status;
  logic [IDX_W-1:0]  tag_probe_idx;

  logic [ADDR_W-1:0] blk_addr, mem_addr, tag_fill_addr, mshr_ready_addr;
  logic              tag_access_en, mshr_add_en, resp_valid, mem_push;
  logic [1:0]        resp_status;
  logic [TAG_W-1:0]  resp_tag, mem_tag;
  logic              tag_fill_by_idx, tag_fill_by_addr, mshr_ready_en, fill_err, tag_flush;
  logic [ADDR_W-1:0] b_blk_addr, b_mem_addr, b_fill_addr, b_ready_addr;
  logic              b_acc, b_add, b_resp_valid, b_push, b_by_idx, b_by_addr, b_ready, b_err, b_flush;
  logic [1:0]        b_status;
  logic [TAG_W-1:0]  b_resp_tag, b_mem_tag;
  logic [IDX_W-1:0]  b_fill_idx, tag_fill_idx;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  nbc_miss_ctrl u0 (
    .clk(clk), .rst(rst), .flush(flush), .req_valid(req_valid), .req_addr(req_addr),
    .req_tag(req_tag), .blk_addr(blk_addr), .tag_status(tag_status),
    .tag_probe_idx(tag_probe_idx), .tag_access_en(tag_access_en), .mshr_hit(mshr_hit),
    .mshr_full(mshr_full), .mshr_add_en(mshr_add_en), .resp_valid(resp_valid),
    .resp_status(resp_status), .resp_tag(resp_tag), .mem_push(mem_push),
    .mem_addr(mem_addr), .mem_tag(mem_tag), .mem_full(mem_full), .fill_valid(fill_valid),
    .fill_tag(fill_tag), .tag_fill_by_idx(tag_fill_by_idx), .tag_fill_idx(tag_fill_idx),
    .tag_fill_by_addr(tag_fill_by_addr), .tag_fill_addr(tag_fill_addr),
    .mshr_ready_en(mshr_ready_en), .mshr_ready_addr(mshr_ready_addr),
    .fill_err(fill_err), .tag_flush(tag_flush)
  );

  nbc_miss_ctrl #(.ALLOC_ON_FILL(1'b1)) u1 (
    .clk(clk), .rst(rst), .flush(flush), .req_valid(req_valid), .req_addr(req_addr),
    .req_tag(req_tag), .blk_addr(b_blk_addr), .tag_status(tag_status),
    .tag_probe_idx(tag_probe_idx), .tag_access_en(b_acc), .mshr_hit(mshr_hit),
    .mshr_full(mshr_full), .mshr_add_en(b_add), .resp_valid(b_resp_valid),
    .resp_status(b_status), .resp_tag(b_resp_tag), .mem_push(b_push),
    .mem_addr(b_mem_addr), .mem_tag(b_mem_tag), .mem_full(mem_full), .fill_valid(fill_valid),
    .fill_tag(fill_tag), .tag_fill_by_idx(b_by_idx), .tag_fill_idx(b_fill_idx),
    .tag_fill_by_addr(b_by_addr), .tag_fill_addr(b_fill_addr),
    .mshr_ready_en(b_ready), .mshr_ready_addr(b_ready_addr),
    .fill_err(b_err), .tag_flush(b_flush)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end

  initial begin
    int exp_tags [4];
    exp_tags = '{6, 8, 9, 10};
    rst = 1'b1; flush = 1'b0; req_valid = 1'b0; req_addr = '0; req_tag = '0;
    tag_status = 2'd0; tag_probe_idx = '0; mshr_hit = 1'b0; mshr_full = 1'b0;
    mem_full = 1'b1; fill_valid = 1'b0; fill_tag = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(!resp_valid && !mem_push && !fill_err && !tag_flush, "R11 reset outputs",
        {resp_valid, mem_push, fill_err, tag_flush}, 0);
    mem_full = 1'b0;
    #1 chk(!mem_push, "R11 queue empty after reset", mem_push, 0);
    mem_full = 1'b1;

    // vector walk, memory port held full
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      req_valid     = 1'b1;
      req_addr      = (i << 6) | 32'h5;
      req_tag       = TAG_W'(i);
      tag_status    = VEC[i][6:5];
      mshr_hit      = VEC[i][4];
      mshr_full     = VEC[i][3];
      tag_probe_idx = IDX_W'(8'h40 + i);
      #1;
      // R1 R2 R3 R4 strobes
      chk(tag_access_en == VEC[i][0] && mshr_add_en == VEC[i][0],
          $sformatf("R1-4 strobes vec %0d", i), {tag_access_en, mshr_add_en}, {2{VEC[i][0]}});
      chk(!mem_push, "R6 held while port full", mem_push, 0);
      @(negedge clk);
      req_valid = 1'b0;
      // R5 response
      chk(resp_valid && resp_tag == TAG_W'(i), $sformatf("R5 resp vec %0d", i),
          {resp_valid, resp_tag}, {1'b1, TAG_W'(i)});
      chk(resp_status == VEC[i][2:1], $sformatf("R1-4 status vec %0d", i), resp_status, VEC[i][2:1]);
    end
    @(negedge clk);
    chk(!resp_valid, "R5 idle no response", resp_valid, 0);

    // drain two, clamp, drain rest (R6, confirms R3 queueing and R1/R2 no queueing)
    mem_full = 1'b0;
    for (int k = 0; k < 4; k++) begin
      if (k == 2) begin
        mem_full = 1'b1;
        repeat (2) begin
          #1 chk(!mem_push && mem_tag == TAG_W'(exp_tags[2]), "R6 head held",
                 {mem_push, mem_tag}, {1'b0, TAG_W'(exp_tags[2])});
          @(negedge clk);
        end
        mem_full = 1'b0;
      end
      #1;
      chk(mem_push && mem_tag == TAG_W'(exp_tags[k]), $sformatf("R6 push order %0d", k),
          {mem_push, mem_tag}, {1'b1, TAG_W'(exp_tags[k])});
      chk(mem_addr == ADDR_W'(exp_tags[k] << 6), "R6 aligned address", mem_addr, exp_tags[k] << 6);
      @(negedge clk);
    end
    #1 chk(!mem_push, "R6 queue drained", mem_push, 0);

    // fill of recorded tag 6 (R7)
    @(negedge clk);
    fill_valid = 1'b1; fill_tag = 4'd6;
    #1;
    chk(tag_fill_by_idx && !tag_fill_by_addr && tag_fill_idx == 8'h46, "R7 fill by index",
        {tag_fill_by_idx, tag_fill_by_addr, tag_fill_idx}, {2'b10, 8'h46});
    chk(b_by_addr && !b_by_idx && b_fill_addr == 32'h180, "R7 fill by address",
        {b_by_addr, b_by_idx, b_fill_addr}, {2'b10, 32'h180});
    chk(mshr_ready_en && mshr_ready_addr == 32'h180, "R7 mark ready",
        {mshr_ready_en, mshr_ready_addr}, {1'b1, 32'h180});
    @(negedge clk);
    chk(!fill_err, "R7 no error on recorded fill", fill_err, 0);
    // second fill same tag (R8)
    #1 chk(!tag_fill_by_idx && !mshr_ready_en, "R8 record released",
           {tag_fill_by_idx, mshr_ready_en}, 0);
    @(negedge clk);
    chk(fill_err, "R8 refill error", fill_err, 1);
    // merged request tag 3 never recorded (R2, R9)
    fill_tag = 4'd3;
    #1 chk(!tag_fill_by_idx && !mshr_ready_en, "R2 merge made no record",
           {tag_fill_by_idx, mshr_ready_en}, 0);
    @(negedge clk);
    chk(fill_err, "R9 unknown tag error", fill_err, 1);
    fill_valid = 1'b0;
    @(negedge clk);
    chk(!fill_err, "R9 error lasts one cycle", fill_err, 0);
    // remaining recorded tag 9 still fills (R7)
    fill_valid = 1'b1; fill_tag = 4'd9;
    #1 chk(tag_fill_by_idx && tag_fill_idx == 8'h49, "R7 other record",
           {tag_fill_by_idx, tag_fill_idx}, {1'b1, 8'h49});
    @(negedge clk);
    fill_valid = 1'b0;

    // flush (R10)
    flush = 1'b1;
    #1 chk(!tag_flush, "R10 not yet forwarded", tag_flush, 0);
    @(negedge clk);
    flush = 1'b0;
    chk(tag_flush, "R10 forwarded", tag_flush, 1);
    @(negedge clk);
    chk(!tag_flush, "R10 released", tag_flush, 0);

    summary();
  end
endmodule